// File: doc/BRIEF.md
# Configuration Image Streaming Engine

This block copies a partial configuration image from an external word-wide memory into an internal byte-wide configuration port. A controller starts a transfer by giving a base word address and a word count. A reader then fetches words one at a time with a request/valid handshake. A small FIFO separates the memory read rate from the port write rate. A serializer splits each 32-bit word into byte writes and holds a byte for as long as the port reports that it is busy.

Memory fetches and port writes overlap in time. The reader keeps fetching while the buffer has room. The serializer drains the buffer independently, so slow memory and a stalling port both cost throughput only where they actually limit it. The transfer reports progress on a busy level, a one-cycle completion pulse, and a one-cycle error pulse for a start that has nothing to send. The default word counter width is 17 bits, which covers a full-device image of 127,581 words.

Top module: `bitstreamLoader`

## Requirements
- R1: A start request in a cycle where busyOut is low and wordCount is nonzero is accepted, and busyOut is high from the next cycle until the transfer ends.
- R2: An accepted transfer issues exactly wordCount memory requests, each a one-cycle memReq pulse, at word addresses baseAddr, baseAddr+1, and so on, wrapping at the address width. No new request is issued until memValid has answered the previous one.
- R3: The reader stops requesting when the FIFO is full. The number of words requested but not yet fully written to the port never exceeds FIFO_DEPTH+1 (the FIFO plus the word being serialized).
- R4: Each word is written as four bytes, bits 31:24 first and bits 7:0 last. A byte is transferred in a cycle where portCe and portWrite are high and portBusy is low.
- R5: If portCe is high and portBusy is high in a cycle, then in the next cycle portCe is still high and portData is unchanged.
- R6: When no transfer is running, memReq, portCe and portWrite are low.
- R7: doneOut is a one-cycle pulse in the cycle after the last byte of the image is transferred, and busyOut is low in that same cycle.
- R8: A start request while busyOut is high is ignored: the running transfer keeps its addresses and its word count.
- R9: A start request with wordCount zero while idle produces a one-cycle errOut pulse in the next cycle, with no memory request, no busy and no done.
- R10: After reset, busyOut, doneOut, errOut, memReq and portCe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a transfer |
| baseAddr | input | ADDR_W | First word address of the image |
| wordCount | input | CNT_W | Number of words in the image |
| busyOut | output | 1 | Transfer in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| errOut | output | 1 | One-cycle pulse for a rejected zero-length start |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | ADDR_W | Word address of the request |
| memValid | input | 1 | Memory returns the requested word |
| memData | input | WORD_W | Returned word |
| portCe | output | 1 | Configuration port chip enable |
| portWrite | output | 1 | Configuration port write enable |
| portData | output | 8 | Configuration byte |
| portBusy | input | 1 | Port cannot take a byte this cycle |

## Verification
The properties assume that memValid is raised only in reply to a pending request, for exactly one cycle per request. A spontaneous or duplicated reply falls outside their scope. The bench memory model answers every observed request exactly once, after a random delay of zero or more cycles, and never otherwise. portBusy is left unconstrained, and is driven at random densities from never to nearly always so that the FIFO both runs dry and fills up.

// File: rtl/cfgLoadPkg.sv
package cfgLoadPkg;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic loadBase;   // latch the start address
    logic issueReq;   // request issued, advance address
    logic pushWord;   // returned word enters the FIFO
    logic popWord;    // FIFO head moves into the serializer
    logic shiftByte;  // current byte taken by the port
  } dpStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } loadState_t;

endpackage

// File: rtl/cfgWordFifo.sv
module cfgWordFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = store[rdPtr];
  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);

endmodule

// File: rtl/cfgLoadDatapath.sv
module cfgLoadDatapath
  import cfgLoadPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        portData,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] headWord;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobes.loadBase) begin
      addrReg <= baseAddr;
    end else if (strobes.issueReq) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  cfgWordFifo #(
    .WIDTH(WORD_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strobes.pushWord),
    .pop   (strobes.popWord),
    .wrData(memData),
    .rdData(headWord),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );

  // A fresh word takes priority over shifting out the last byte of the old one.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.popWord) begin
      shiftReg <= headWord;
    end else if (strobes.shiftByte) begin
      shiftReg <= {shiftReg[WORD_W-9:0], 8'h00};
    end
  end

  assign memAddr  = addrReg;
  assign portData = shiftReg[WORD_W-1 -: 8];

endmodule

// File: rtl/cfgLoadCtrl.sv
module cfgLoadCtrl
  import cfgLoadPkg::*;
#(
  parameter int CNT_W = 17,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             memValid,
  input  logic             portBusy,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output dpStrobes_t       strobes,
  output logic             busyOut,
  output logic             doneOut,
  output logic             errOut,
  output logic             memReq,
  output logic             portCe,
  output logic             portWrite
);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  loadState_t       state;
  logic [CNT_W-1:0] reqLeft;
  logic [CNT_W-1:0] sendLeft;
  logic             outstanding;
  logic             haveWord;
  logic [IDX_W-1:0] byteIdx;

  logic startOk, startBad, accept, lastByte, wordDone, finalWord;
  logic issue, push, pop;

  always_comb begin
    startOk   = (state == ST_IDLE) && startReq && (wordCount != '0);
    startBad  = (state == ST_IDLE) && startReq && (wordCount == '0);
    accept    = haveWord && !portBusy;
    lastByte  = (byteIdx == IDX_W'(BYTES - 1));
    wordDone  = accept && lastByte;
    finalWord = (sendLeft == CNT_W'(1));
    issue     = (state == ST_RUN) && (reqLeft != '0) && !outstanding && !fifoFull;
    push      = memValid && outstanding;
    pop       = (state == ST_RUN) && !fifoEmpty &&
                (!haveWord || (wordDone && !finalWord));

    strobes.loadBase  = startOk;
    strobes.issueReq  = issue;
    strobes.pushWord  = push;
    strobes.popWord   = pop;
    strobes.shiftByte = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      reqLeft     <= '0;
      sendLeft    <= '0;
      outstanding <= 1'b0;
      haveWord    <= 1'b0;
      byteIdx     <= '0;
      doneOut     <= 1'b0;
      errOut      <= 1'b0;
    end else begin
      doneOut <= wordDone && finalWord;
      errOut  <= startBad;

      if (startOk) begin
        state    <= ST_RUN;
        reqLeft  <= wordCount;
        sendLeft <= wordCount;
        byteIdx  <= '0;
      end else begin
        if (wordDone && finalWord) state <= ST_IDLE;
        if (issue)    reqLeft  <= reqLeft - 1'b1;
        if (wordDone) sendLeft <= sendLeft - 1'b1;
        if (accept)   byteIdx  <= lastByte ? '0 : byteIdx + 1'b1;
      end

      if (issue)     outstanding <= 1'b1;
      else if (push) outstanding <= 1'b0;

      if (pop)           haveWord <= 1'b1;
      else if (wordDone) haveWord <= 1'b0;
    end
  end

  assign busyOut   = (state == ST_RUN);
  assign memReq    = issue;
  assign portCe    = haveWord;
  assign portWrite = haveWord;

endmodule

// File: rtl/bitstreamLoader.sv
module bitstreamLoader
  import cfgLoadPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 17,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busyOut,
  output logic              doneOut,
  output logic              errOut,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic              portCe,
  output logic              portWrite,
  output logic [7:0]        portData,
  input  logic              portBusy
);
  localparam int BYTES = WORD_W / 8;

  dpStrobes_t strobes;
  logic fifoFull, fifoEmpty;
  logic pushW, popW;

  cfgLoadCtrl #(
    .CNT_W(CNT_W),
    .BYTES(BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .wordCount(wordCount),
    .memValid (memValid),
    .portBusy (portBusy),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .strobes  (strobes),
    .busyOut  (busyOut),
    .doneOut  (doneOut),
    .errOut   (errOut),
    .memReq   (memReq),
    .portCe   (portCe),
    .portWrite(portWrite)
  );

  cfgLoadDatapath #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .baseAddr (baseAddr),
    .memData  (memData),
    .memAddr  (memAddr),
    .portData (portData),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty)
  );

  assign pushW = strobes.pushWord;
  assign popW  = strobes.popWord;

endmodule

// File: rtl/cfgLoadChecker.sv
module cfgLoadChecker #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [CNT_W-1:0] wordCount,
  input logic             busyOut,
  input logic             doneOut,
  input logic             errOut,
  input logic             memReq,
  input logic             portCe,
  input logic             portBusy,
  input logic [7:0]       portData,
  input logic             fifoFull,
  input logic             pushWord
);

  assert_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busyOut && (wordCount != '0)) |=> busyOut);

  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !pushWord);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (portCe && portBusy) |=> (portCe && $stable(portData)));

  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> (!memReq && !portCe));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busyOut);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> doneOut);

  assert_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (!busyOut && !doneOut));

endmodule

bind bitstreamLoader cfgLoadChecker #(
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .wordCount(wordCount),
  .busyOut  (busyOut),
  .doneOut  (doneOut),
  .errOut   (errOut),
  .memReq   (memReq),
  .portCe   (portCe),
  .portBusy (portBusy),
  .portData (portData),
  .fifoFull (fifoFull),
  .pushWord (pushW)
);

// File: tb/sim_bitstreamLoader.sv
module sim_bitstreamLoader;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W   = 24;
  localparam int CNT_W    = 17;
  localparam int WORD_W   = 32;
  localparam int DEPTH    = 4;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [CNT_W-1:0]  wordCount = '0;
  logic              busyOut, doneOut, errOut, memReq, portCe, portWrite;
  logic [ADDR_W-1:0] memAddr;
  logic              memValid = 1'b0;
  logic [WORD_W-1:0] memData = '0;
  logic [7:0]        portData;
  logic              portBusy = 1'b0;

  always #2.5 clk = ~clk;

  bitstreamLoader #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_W(WORD_W), .FIFO_DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .baseAddr(baseAddr),
    .wordCount(wordCount), .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .portCe(portCe), .portWrite(portWrite), .portData(portData), .portBusy(portBusy)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timedOut = 0;

  // stimulus knobs and model state
  bit                startNext = 0;
  logic [ADDR_W-1:0] startBase = '0;
  logic [CNT_W-1:0]  startCount = '0;
  int                busyPct = 0;
  int                maxLat = 0;
  bit                memPending = 0;
  int                memDelay = 0;
  logic [ADDR_W-1:0] memPendAddr = '0;

  // expectations
  logic [ADDR_W-1:0] xferBase = '0;
  logic [ADDR_W-1:0] expAddr = '0;
  int  reqCnt = 0;
  int  reqTarget = 0;
  int  acceptCnt = 0;
  int  expBytes = 0;
  bit  doneExpNext = 0;
  bit  errExpNext = 0;
  bit  busyExpNext = 0;
  bit  doneSeen = 0;
  bit  prevHold = 0;
  logic [7:0] prevData = '0;

  function automatic logic [WORD_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    logic [31:0] x;
    x = {8'h00, a} * 32'h9E3779B1;
    return x ^ 32'h5A0FC3A5;
  endfunction

  function automatic logic [7:0] byteOf(input logic [WORD_W-1:0] w, input int k);
    return w[WORD_W-1-8*k -: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic stepCycle();
    logic [7:0] expByte;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG && !timedOut) begin
      timedOut = 1;
      chk(0, "watchdog", cycles, WATCHDOG);
    end
    // drive
    startReq  = startNext;
    baseAddr  = startBase;
    wordCount = startCount;
    startNext = 0;
    portBusy  = ($urandom_range(99) < busyPct);
    if (memPending && memDelay == 0) begin
      memValid   = 1'b1;
      memData    = memWord(memPendAddr);
      memPending = 0;
    end else begin
      memValid = 1'b0;
      memData  = $urandom;
      if (memPending) memDelay--;
    end
    #1;
    // observe
    if (doneOut || doneExpNext) chk(doneOut == doneExpNext, "R7 done timing", doneOut, doneExpNext);
    if (doneOut) begin
      doneSeen = 1;
      chk(!busyOut, "R7 busy low at done", busyOut, 0);
    end
    if (errOut || errExpNext) chk(errOut == errExpNext, "R9 err pulse", errOut, errExpNext);
    if (busyExpNext) chk(busyOut, "R1 busy after start", busyOut, 1);
    doneExpNext = 0;
    errExpNext  = 0;
    busyExpNext = 0;

    if (prevHold) begin
      chk(portCe, "R5 ce held while busy", portCe, 1);
      chk(portData == prevData, "R5 byte held while busy", portData, prevData);
    end
    chk(portCe == portWrite, "R4 ce equals write", portWrite, portCe);

    if (memReq) begin
      chk(memAddr == expAddr, "R2 request address", memAddr, expAddr);
      chk(reqCnt < reqTarget, "R2 request count", reqCnt + 1, reqTarget);
      chk(!memPending, "R2 one outstanding", 1, 0);
      memPending  = 1;
      memPendAddr = memAddr;
      memDelay    = $urandom_range(maxLat);
      expAddr     = expAddr + 1'b1;
      reqCnt++;
      chk(reqCnt - acceptCnt / 4 <= DEPTH + 1, "R3 buffer bound", reqCnt - acceptCnt / 4, DEPTH + 1);
    end

    if (portCe && !portBusy) begin
      expByte = byteOf(memWord(ADDR_W'(xferBase + ADDR_W'(acceptCnt / 4))), acceptCnt % 4);
      chk(portData == expByte, "R4 byte value/order", portData, expByte);
      acceptCnt++;
      if (acceptCnt == expBytes) doneExpNext = 1;
    end

    prevHold = portCe && portBusy;
    prevData = portData;

    if (startReq && !busyOut) begin
      if (wordCount == '0) errExpNext = 1;
      else busyExpNext = 1;
    end
  endtask

  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      stepCycle();
      chk(!memReq && !portCe && !portWrite && !busyOut, "R6 quiet when idle",
          {memReq, portCe, portWrite, busyOut}, 0);
    end
  endtask

  task automatic runXfer(input logic [ADDR_W-1:0] base, input int count,
                         input int bPct, input int lat, input bit injectStart);
    int n;
    busyPct   = bPct;
    maxLat    = lat;
    xferBase  = base;
    expAddr   = base;
    reqCnt    = 0;
    reqTarget = count;
    acceptCnt = 0;
    expBytes  = count * 4;
    doneSeen  = 0;
    startNext = 1;
    startBase = base;
    startCount = CNT_W'(count);
    stepCycle();
    n = 0;
    while (!doneSeen && !timedOut) begin
      stepCycle();
      n++;
      if (injectStart && n == 5) begin
        // R8: must be ignored while busy
        startNext  = 1;
        startBase  = base + 24'h100;
        startCount = 3;
      end
    end
    chk(reqCnt == count, "R2 total requests", reqCnt, count);
    chk(acceptCnt == count * 4, "R4 total bytes", acceptCnt, count * 4);
    if (injectStart) chk(doneSeen && reqCnt == count, "R8 start ignored", reqCnt, count);
    idleCheck(3);
  endtask

  task automatic zeroStart();
    busyPct    = 0;
    reqTarget  = 0;
    reqCnt     = 0;
    startNext  = 1;
    startBase  = 24'h777;
    startCount = '0;
    stepCycle();
    stepCycle();
    chk(!busyOut, "R9 no busy on zero count", busyOut, 0);
    idleCheck(3);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busyOut, "R10 reset busy", busyOut, 0);
    chk(!doneOut, "R10 reset done", doneOut, 0);
    chk(!errOut, "R10 reset err", errOut, 0);
    chk(!memReq, "R10 reset memReq", memReq, 0);
    chk(!portCe, "R10 reset portCe", portCe, 0);
    rstN = 1'b1;
    idleCheck(2);

    // directed corners
    runXfer(24'h000100, 1, 0, 0, 0);      // single word, no stalls
    runXfer(24'h000200, 1, 80, 3, 0);     // single word, heavy port stall
    runXfer(24'h000300, 6, 0, 0, 0);      // back-to-back streaming
    zeroStart();                          // R9
    runXfer(24'h000400, 20, 90, 0, 0);    // port slow, memory fast: FIFO fills (R3)
    runXfer(24'h000500, 12, 30, 2, 1);    // start during transfer (R8)
    runXfer(24'hFFFFFE, 4, 20, 1, 0);     // address wrap (R2)
    runXfer(24'h000600, 9, 0, 6, 0);      // slow memory, FIFO runs dry

    // constrained random
    for (int t = 0; t < 10 && !timedOut; t++) begin
      runXfer(ADDR_W'($urandom), 1 + $urandom_range(39), $urandom_range(70),
              $urandom_range(5), $urandom_range(3) == 0);
    end
    zeroStart();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule